// File: doc/BRIEF.md
# Branch Clock Gate with Running Status

This block passes a free-running source clock onto one output branch when software asks for it, and tells software whether the branch is actually running. Two registers control it. The control register holds a direct enable bit and shows the true branch state in its upper nibble. The vote register holds a small set of vote bits, and any one of them turns the branch on without touching the direct enable.

A combined request, the enable ORed with every vote bit, is registered in the register clock domain. It passes through a two-flop synchroniser into the source clock domain and drives a latch that is open while the source clock is low, so the gated output never carries a shortened pulse. A flop clocked by the source clock records that the gated clock has produced a rising edge. A second two-flop synchroniser brings that state back to the register clock. Software sets the enable and then polls until the off flag clears. When the flag clears, the branch clock is already toggling.

A one-bit stub input from the bus fabric marks that a fabric-side state machine manages the branch. While the branch is on, this input changes the reported status code.

Top module: `bcg_branch_gate`

## Requirements
- R1: Bit 0 of the control register (select 0) is a read/write enable. It resets to 0, so the control register reads 0x80000000 after reset.
- R2: Bit 31 of the control register reads 1 while the branch is off, and clk_out stays low while it is off.
- R3: After the enable is set, bit 31 clears within 16 register-clock cycles, and never before clk_out has produced at least one rising edge.
- R4: The 4-bit status code in bits 31:28 reads 4'b1000 when the branch is off. When it is on, the code reads 4'b0000, or 4'b0010 (only bit 29 set) while fabric_fsm is high. fabric_fsm has no effect while the branch is off.
- R5: The vote register (select 1) holds VOTE_W read/write bits in its low bits, and its upper bits read 0. Any nonzero vote turns the branch on and leaves control bit 0 unchanged. Clearing all votes while bit 0 is 0 turns the branch off. Clearing all votes while bit 0 is 1 keeps the branch on.
- R6: Writes to control bits 31:1 are ignored, and control bits 27:1 always read 0.
- R7: When the last request is removed, clk_out stops and stays low, and bit 31 returns to 1 within 16 register-clock cycles.
- R8: A read returns data with rd_valid exactly one register-clock cycle after rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| src_clk | input | 1 | Free-running source clock to be gated |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 vote |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read target: 0 control, 1 vote |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| fabric_fsm | input | 1 | Stub: fabric state machine manages the branch |
| clk_out | output | 1 | Gated branch clock |

## Verification
The hardest point to reach is the moment the off flag first clears. The two clocks have no fixed phase relation and the round trip crosses four synchroniser stages, so the exact cycle cannot be predicted. The bench therefore polls the control register right after the enable write, the way software would. It records the cycle of the first clear read and compares that against a bound. It also counts the rising edges of clk_out seen since the write, which proves that the clock ran before the flag cleared. Vote-only turn-on is checked the same way, and so is the case where a vote is removed while the direct enable still holds the branch on.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int REG_W = 32;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_VOTE = 1'b1
  } bcg_sel_e;

  localparam logic [3:0] ST_OFF    = 4'b1000;
  localparam logic [3:0] ST_ON     = 4'b0000;
  localparam logic [3:0] ST_FABRIC = 4'b0010;

  // Status nibble from the synchronised branch state
  function automatic logic [3:0] status_code(input logic on, input logic fabric);
    if (!on)        return ST_OFF;
    else if (fabric) return ST_FABRIC;
    else            return ST_ON;
  endfunction

  // Control readback word: status nibble on top, enable at bit 0
  function automatic logic [REG_W-1:0] ctrl_word(input logic [3:0] st, input logic en);
    return {st, {(REG_W-5){1'b0}}, en};
  endfunction
endpackage

// File: rtl/bcg_sync.sv
module bcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bcg_gate.sv
module bcg_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic req_async,
  output logic clk_out,
  output logic running
);
  logic req_src;
  logic en_lat;
  logic run_q;

  bcg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d     (req_async),
    .q     (req_src)
  );

  // Transparent while the source clock is low: the enable only moves
  // in the low phase, so the AND below cannot cut a high pulse short.
  always_latch begin
    if (!src_clk) en_lat = req_src;
  end

  assign clk_out = src_clk & en_lat;

  // Set on a rising edge that the gate let through
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en_lat;
  end

  assign running = run_q;
endmodule

// File: rtl/bcg_regs.sv
module bcg_regs
  import bcg_pkg::*;
#(
  parameter int VOTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_sel,
  input  logic             on_flag,
  input  logic             fabric_fsm,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             en,
  output logic             req
);
  logic              en_q;
  logic [VOTE_W-1:0] vote_q;
  logic              req_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:VOTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      vote_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) en_q   <= wr_data[0];
      else                    vote_q <= wr_data[VOTE_W-1:0];
    end
  end

  // Registered so that only a clean flop output crosses domains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= en_q | (|vote_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (rd_sel == SEL_CTRL)
          rd_data <= ctrl_word(status_code(on_flag, fabric_fsm), en_q);
        else
          rd_data <= {{(REG_W-VOTE_W){1'b0}}, vote_q};
      end
    end
  end

  assign en  = en_q;
  assign req = req_q;
endmodule

// File: rtl/bcg_branch_gate.sv
module bcg_branch_gate
  import bcg_pkg::*;
#(
  parameter int VOTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_clk,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        fabric_fsm,
  output logic        clk_out
);
  // Named internal events for the checker
  logic en_w;
  logic req_w;
  logic running_w;
  logic on_sync_w;

  bcg_regs #(.VOTE_W(VOTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .on_flag    (on_sync_w),
    .fabric_fsm (fabric_fsm),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .en         (en_w),
    .req        (req_w)
  );

  bcg_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .src_clk   (src_clk),
    .rst_n     (rst_n),
    .req_async (req_w),
    .clk_out   (clk_out),
    .running   (running_w)
  );

  bcg_sync #(.STAGES(SYNC_STAGES)) u_state_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (running_w),
    .q     (on_sync_w)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic        wr_bit0,
  input logic        rd_sel,
  input logic        rd_valid,
  input logic [31:1] rd_hi,
  input logic        en,
  input logic        on_sync
);
  // R1: a control write sets the enable to the written bit 0
  p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (en == $past(wr_bit0)));

  // R2: off flag in readback mirrors the synchronised state at read time
  p_off_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_sel)) |-> (rd_hi[31] == !$past(on_sync)));

  // R4: while on, the status nibble is one of the two on codes
  p_status_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_sel) && $past(on_sync)) |->
      (rd_hi[31:28] == 4'b0000 || rd_hi[31:28] == 4'b0010));

  // R5: a vote write never moves the direct enable
  p_vote_keeps_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(en));

  // R6: reserved control bits read zero
  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_sel)) |-> (rd_hi[27:1] == '0));
endmodule

bind bcg_branch_gate bcg_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_bit0  (wr_data[0]),
  .rd_sel   (rd_sel),
  .rd_valid (rd_valid),
  .rd_hi    (rd_data[31:1]),
  .en       (en_w),
  .on_sync  (on_sync_w)
);

// File: tb/sim_bcg_branch_gate.sv
`timescale 1ns/100ps
module sim_bcg_branch_gate;
  logic        clk = 1'b0;
  logic        src_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        fabric_fsm = 1'b0;
  logic        clk_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int edges = 0;
  logic [31:0] last_rd;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb[$];

  bcg_branch_gate u0 (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .fabric_fsm(fabric_fsm),
    .clk_out(clk_out)
  );

  always #5 clk = ~clk;
  always #3.5 src_clk = ~src_clk;
  always @(posedge clk) cyc++;
  always @(posedge clk_out) edges++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (rd_valid) begin
      item_t it;
      last_rd = rd_data;
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected rd_valid", rd_data, 32'h0);
      end else begin
        it = sb.pop_front();
        if (it.mask != 0)
          check(((rd_data ^ it.exp) & it.mask) == 0, it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] exp, input logic [31:0] mask,
                    input string tag);
    item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    if (mask != 0) check(rd_valid == 1'b1, "R8 rd_valid one cycle after rd_en",
                         {31'b0, rd_valid}, 32'h1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t0;
    int e0;
    int took;
    bit cleared;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // Reset state
    rd(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R1 R2 ctrl after reset");
    rd(1'b1, 32'h0, 32'hFFFF_FFFF, "R5 vote after reset");
    check(edges == 0, "R2 no clk_out edges while off", edges, 0);
    check(clk_out == 1'b0, "R2 clk_out low while off", {31'b0, clk_out}, 0);

    // Read-only bits ignored with enable 0
    wr(1'b0, 32'hFFFF_FFFE);
    idle(20);
    rd(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R6 ctrl write to bits 31:1 ignored");
    fabric_fsm = 1'b1;
    rd(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R4 fabric_fsm ignored while off");
    fabric_fsm = 1'b0;

    // Enable and poll
    e0 = edges;
    wr(1'b0, 32'h1);
    t0 = cyc;
    cleared = 0;
    took = 0;
    for (int k = 0; k < 20 && !cleared; k++) begin
      rd(1'b0, 32'h0, 32'h0, "poll");
      if (last_rd[31] == 1'b0) begin
        cleared = 1;
        took = cyc - t0;
        check(edges > e0, "R3 clk_out toggled before off flag cleared", edges - e0, 1);
      end
    end
    check(cleared && took <= 16, "R3 off flag clears within 16 cycles", took, 16);
    idle(10);
    rd(1'b0, 32'h0000_0001, 32'hFFFF_FFFF, "R4 status code on");
    fabric_fsm = 1'b1;
    rd(1'b0, 32'h2000_0001, 32'hFFFF_FFFF, "R4 status code fabric managed");
    fabric_fsm = 1'b0;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 32'h0000_0001, 32'hFFFF_FFFF, "R6 ctrl bits 31:1 ignored while on");

    // Disable
    wr(1'b0, 32'h0);
    idle(16);
    rd(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R7 off flag back within 16 cycles");
    e0 = edges;
    idle(20);
    check(edges == e0, "R7 clk_out stopped", edges - e0, 0);
    check(clk_out == 1'b0, "R7 clk_out low", {31'b0, clk_out}, 0);

    // Vote-only turn on
    wr(1'b1, 32'h0000_0104);
    rd(1'b1, 32'h0000_0004, 32'hFFFF_FFFF, "R5 vote bits, upper bits read 0");
    idle(20);
    rd(1'b0, 32'h0000_0000, 32'hFFFF_FFFF, "R5 vote on, enable bit unchanged");
    e0 = edges;
    idle(5);
    check(edges > e0, "R5 clk_out toggling on vote", edges - e0, 1);

    // Remove vote with enable 0
    wr(1'b1, 32'h0);
    idle(20);
    rd(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R5 clearing votes turns branch off");

    // Vote removed while enable holds
    wr(1'b0, 32'h1);
    wr(1'b1, 32'h80);
    idle(20);
    wr(1'b1, 32'h0);
    idle(20);
    rd(1'b0, 32'h0000_0001, 32'hFFFF_FFFF, "R5 enable keeps branch on after votes cleared");
    e0 = edges;
    idle(5);
    check(edges > e0, "R5 clk_out still toggling", edges - e0, 1);

    idle(3);
    check(sb.size() == 0, "R8 every read returned data", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule